// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Burst Address Counters

This block is a true dual-port synchronous memory. Each of its two ports has its own clock and reset, and each can read or write any word of the shared array. A port samples all of its inputs on its own rising clock edge. Writes are masked per byte lane: four 9-bit lanes make up one 36-bit word. The depth is set by a parameter. The default of 256 words keeps elaboration small, and a 16K-word build sets the address width to 14.

Each port has a burst counter that supplies the access address.

- A strobe loads an external address.
- An advance input steps the counter by one.
- A clear input forces address zero.
- With none of these active, the counter holds its value, so a burst can be stalled.

Reads are pipelined. The array is read one edge after the access edge, and an output register is loaded on the edge after that. A two-input chip select powers a port down for a cycle. After a deselect, a port needs two selected edges before its read results are flagged valid again. An output-enable input gates the read data and its valid flag without waiting for a clock edge.

Top module: `dpr_sync_ram`

## Requirements
- R1: When the load strobe (`x_load_n`) is low and clear is inactive, the access on that edge uses `x_addr`, and the counter takes that value.
- R2: When load is inactive, clear is inactive and advance (`x_step_n`) is low, the access uses the counter value plus one, and the counter keeps it. The step from the top address wraps to 0.
- R3: When load, advance and clear are all inactive, the access repeats the counter address. Repeated reads then keep the output word unchanged.
- R4: Clear (`x_zero_n` low) has priority over load and advance. The access on that same edge, whether a read or a write, goes to address 0.
- R5: A read accessed on edge k shows its word on `x_q` from edge k+2. Between valid reads, `x_q` holds the last read word, and `x_q_vld` is high for one cycle per valid read.
- R6: In a write, lane i (bits 9i+8..9i) is stored only when `x_lane_n[i]` is low. The other lanes of the word keep their contents.
- R7: An edge with `x_sel_n` high or `x_sel` low is a deselected cycle. On that edge no write happens, the counter holds, and any read is not flagged valid.
- R8: A read is flagged valid only if the port was selected on its access edge and on the edge before it. The cycle before the first edge after reset counts as deselected.
- R9: `x_oe_n` high forces `x_q` to zero and `x_q_vld` low at once, without a clock edge. When it returns low, the registered word and flag reappear.
- R10: A word written through one port is returned by a later read through the other port. When the two ports write different lanes of one word on different edges, each lane keeps the latest write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| a_sel_n | input | 1 | Port A select, active low |
| a_sel | input | 1 | Port A select, active high |
| a_rd | input | 1 | Port A direction: 1 read, 0 write |
| a_load_n | input | 1 | Port A address load strobe, active low |
| a_step_n | input | 1 | Port A counter advance, active low |
| a_zero_n | input | 1 | Port A counter clear, active low |
| a_lane_n | input | 4 | Port A byte-lane write enables, active low |
| a_oe_n | input | 1 | Port A output enable, active low, asynchronous |
| a_addr | input | ADDR_W | Port A external address |
| a_wdata | input | 36 | Port A write data |
| a_q | output | 36 | Port A read data |
| a_q_vld | output | 1 | Port A read data valid |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| b_sel_n | input | 1 | Port B select, active low |
| b_sel | input | 1 | Port B select, active high |
| b_rd | input | 1 | Port B direction: 1 read, 0 write |
| b_load_n | input | 1 | Port B address load strobe, active low |
| b_step_n | input | 1 | Port B counter advance, active low |
| b_zero_n | input | 1 | Port B counter clear, active low |
| b_lane_n | input | 4 | Port B byte-lane write enables, active low |
| b_oe_n | input | 1 | Port B output enable, active low, asynchronous |
| b_addr | input | ADDR_W | Port B external address |
| b_wdata | input | 36 | Port B write data |
| b_q | output | 36 | Port B read data |
| b_q_vld | output | 1 | Port B read data valid |

## Verification
The counter and latency properties assume that each port's reset is held low through at least one of its clock edges before the first access. They also assume that the port inputs carry known values at every edge. Nothing here resolves a collision, so the stimulus never has both ports write the same lane of a word on the same edge. It also never has one port read a word on the same edge the other port writes it. Both ports run from one bench clock, which makes the cross-port ordering exact, and every other access pattern (bursts, wraps, clears during loads, deselects and output-enable toggling) is driven freely.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;

   // Counter operation, listed from lowest to highest priority
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_STEP  = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } cnt_op_e;

   // Clear beats load, load beats advance
   function automatic cnt_op_e pick_op(input logic clr, input logic load, input logic step);
      if (clr)       return OP_CLEAR;
      else if (load) return OP_LOAD;
      else if (step) return OP_STEP;
      else           return OP_HOLD;
   endfunction

endpackage

// File: rtl/dpr_addr_counter.sv
`timescale 1ns/1ps
module dpr_addr_counter
   import dpr_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          clr,
   input  logic          load,
   input  logic          step,
   input  logic [AW-1:0] ext_addr,
   output logic [AW-1:0] nxt,
   output logic [AW-1:0] cur
);

   cnt_op_e op;

   assign op = pick_op(clr, load, step);

   always_comb begin
      unique case (op)
         OP_CLEAR: nxt = '0;
         OP_LOAD:  nxt = ext_addr;
         OP_STEP:  nxt = cur + 1'b1;
         default:  nxt = cur;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cur <= '0;
      else if (en) cur <= nxt;
   end

   // R4: clear wins and lands on zero
   p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      en && clr |=> cur == '0);

   // R1: load takes the external address
   p_load_takes_r1: assert property (@(posedge clk) disable iff (!rst_n)
      en && !clr && load |=> cur == $past(ext_addr));

   // R2: advance adds one, wrapping at the top
   p_step_plus_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en && !clr && !load && step |=> cur == $past(cur) + 1'b1);

   // R3 / R7: idle or deselected edges leave the counter alone
   p_hold_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en || (!clr && !load && !step)) |=> $stable(cur));

endmodule

// File: rtl/dpr_lvt_bank.sv
`timescale 1ns/1ps
module dpr_lvt_bank #(
   parameter int AW     = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk_a,
   input  logic                    wr_a,
   input  logic [AW-1:0]           waddr_a,
   input  logic [LANES-1:0]        lanes_a,
   input  logic [LANES*LANE_W-1:0] wdata_a,
   input  logic [AW-1:0]           raddr_a,
   output logic [LANES*LANE_W-1:0] rdata_a,
   input  logic                    clk_b,
   input  logic                    wr_b,
   input  logic [AW-1:0]           waddr_b,
   input  logic [LANES-1:0]        lanes_b,
   input  logic [LANES*LANE_W-1:0] wdata_b,
   input  logic [AW-1:0]           raddr_b,
   output logic [LANES*LANE_W-1:0] rdata_b
);

   localparam int DEPTH = 1 << AW;

   // Each lane has one store per port; the XOR of the two owner bits names the latest writer
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] store_a [DEPTH];
      logic [LANE_W-1:0] store_b [DEPTH];
      logic [DEPTH-1:0]  own_a;
      logic [DEPTH-1:0]  own_b;

      always_ff @(posedge clk_a) begin
         if (wr_a && lanes_a[l]) begin
            store_a[waddr_a] <= wdata_a[l*LANE_W +: LANE_W];
            own_a[waddr_a]   <= own_b[waddr_a];
         end
      end

      always_ff @(posedge clk_b) begin
         if (wr_b && lanes_b[l]) begin
            store_b[waddr_b] <= wdata_b[l*LANE_W +: LANE_W];
            own_b[waddr_b]   <= ~own_a[waddr_b];
         end
      end

      assign rdata_a[l*LANE_W +: LANE_W] = (own_a[raddr_a] ^ own_b[raddr_a]) ?
                                           store_b[raddr_a] : store_a[raddr_a];
      assign rdata_b[l*LANE_W +: LANE_W] = (own_a[raddr_b] ^ own_b[raddr_b]) ?
                                           store_b[raddr_b] : store_a[raddr_b];
   end

endmodule

// File: rtl/dpr_port.sv
`timescale 1ns/1ps
module dpr_port #(
   parameter int AW    = 8,
   parameter int LANES = 4,
   parameter int DW    = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_n,
   input  logic             sel_h,
   input  logic             rd,
   input  logic             load_n,
   input  logic             step_n,
   input  logic             zero_n,
   input  logic [LANES-1:0] lane_n,
   input  logic             oe_n,
   input  logic [AW-1:0]    addr,
   output logic             mem_wr,
   output logic [AW-1:0]    mem_waddr,
   output logic [LANES-1:0] mem_lanes,
   output logic [AW-1:0]    mem_raddr,
   input  logic [DW-1:0]    mem_rdata,
   output logic [DW-1:0]    q,
   output logic             q_vld
);

   logic          sel;
   logic          sel_prev;
   logic          acc_rd;
   logic          rd_busy;
   logic [DW-1:0] rd_word;
   logic [DW-1:0] q_reg;
   logic          vld_reg;
   logic [AW-1:0] cnt_nxt;
   logic [AW-1:0] cnt_cur;

   assign sel = !sel_n && sel_h;

   dpr_addr_counter #(.AW(AW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (sel),
      .clr      (!zero_n),
      .load     (!load_n),
      .step     (!step_n),
      .ext_addr (addr),
      .nxt      (cnt_nxt),
      .cur      (cnt_cur)
   );

   assign mem_wr    = sel && !rd;
   assign mem_waddr = cnt_nxt;
   assign mem_lanes = ~lane_n;
   assign mem_raddr = cnt_cur;

   // Stage 0: access edge; stage 1: array read; stage 2: output register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_prev <= 1'b0;
         acc_rd   <= 1'b0;
         rd_busy  <= 1'b0;
         rd_word  <= '0;
         q_reg    <= '0;
         vld_reg  <= 1'b0;
      end else begin
         sel_prev <= sel;
         acc_rd   <= sel && sel_prev && rd;
         rd_busy  <= acc_rd;
         if (acc_rd)  rd_word <= mem_rdata;
         vld_reg  <= rd_busy;
         if (rd_busy) q_reg <= rd_word;
      end
   end

   assign q     = oe_n ? '0 : q_reg;
   assign q_vld = !oe_n && vld_reg;

   // R5 / R8: a valid result traces back three edges to a read on two selected edges
   p_read_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vld_reg |-> $past(rd, 3) && $past(sel, 3) && $past(sel, 4));

   // R7: a deselected edge never starts a valid result
   p_desel_no_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> !acc_rd);

endmodule

// File: rtl/dpr_sync_ram.sv
`timescale 1ns/1ps
module dpr_sync_ram #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk_a,
   input  logic                    rst_a_n,
   input  logic                    a_sel_n,
   input  logic                    a_sel,
   input  logic                    a_rd,
   input  logic                    a_load_n,
   input  logic                    a_step_n,
   input  logic                    a_zero_n,
   input  logic [LANES-1:0]        a_lane_n,
   input  logic                    a_oe_n,
   input  logic [ADDR_W-1:0]       a_addr,
   input  logic [LANES*LANE_W-1:0] a_wdata,
   output logic [LANES*LANE_W-1:0] a_q,
   output logic                    a_q_vld,
   input  logic                    clk_b,
   input  logic                    rst_b_n,
   input  logic                    b_sel_n,
   input  logic                    b_sel,
   input  logic                    b_rd,
   input  logic                    b_load_n,
   input  logic                    b_step_n,
   input  logic                    b_zero_n,
   input  logic [LANES-1:0]        b_lane_n,
   input  logic                    b_oe_n,
   input  logic [ADDR_W-1:0]       b_addr,
   input  logic [LANES*LANE_W-1:0] b_wdata,
   output logic [LANES*LANE_W-1:0] b_q,
   output logic                    b_q_vld
);

   localparam int DW     = LANES * LANE_W;
   localparam int NPORTS = 2;

   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_aw
      $error("dpr_sync_ram: ADDR_W must lie in 2..16");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("dpr_sync_ram: LANES and LANE_W must be positive");
   end

   logic              clk_v    [NPORTS];
   logic              rstn_v   [NPORTS];
   logic              seln_v   [NPORTS];
   logic              selh_v   [NPORTS];
   logic              rd_v     [NPORTS];
   logic              loadn_v  [NPORTS];
   logic              stepn_v  [NPORTS];
   logic              zeron_v  [NPORTS];
   logic [LANES-1:0]  lanen_v  [NPORTS];
   logic              oen_v    [NPORTS];
   logic [ADDR_W-1:0] addr_v   [NPORTS];
   logic              wr_v     [NPORTS];
   logic [ADDR_W-1:0] waddr_v  [NPORTS];
   logic [LANES-1:0]  lanes_v  [NPORTS];
   logic [ADDR_W-1:0] raddr_v  [NPORTS];
   logic [DW-1:0]     rdata_v  [NPORTS];
   logic [DW-1:0]     q_v      [NPORTS];
   logic              qvld_v   [NPORTS];

   assign clk_v[0]   = clk_a;    assign clk_v[1]   = clk_b;
   assign rstn_v[0]  = rst_a_n;  assign rstn_v[1]  = rst_b_n;
   assign seln_v[0]  = a_sel_n;  assign seln_v[1]  = b_sel_n;
   assign selh_v[0]  = a_sel;    assign selh_v[1]  = b_sel;
   assign rd_v[0]    = a_rd;     assign rd_v[1]    = b_rd;
   assign loadn_v[0] = a_load_n; assign loadn_v[1] = b_load_n;
   assign stepn_v[0] = a_step_n; assign stepn_v[1] = b_step_n;
   assign zeron_v[0] = a_zero_n; assign zeron_v[1] = b_zero_n;
   assign lanen_v[0] = a_lane_n; assign lanen_v[1] = b_lane_n;
   assign oen_v[0]   = a_oe_n;   assign oen_v[1]   = b_oe_n;
   assign addr_v[0]  = a_addr;   assign addr_v[1]  = b_addr;

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      dpr_port #(.AW(ADDR_W), .LANES(LANES), .DW(DW)) u_port (
         .clk       (clk_v[p]),
         .rst_n     (rstn_v[p]),
         .sel_n     (seln_v[p]),
         .sel_h     (selh_v[p]),
         .rd        (rd_v[p]),
         .load_n    (loadn_v[p]),
         .step_n    (stepn_v[p]),
         .zero_n    (zeron_v[p]),
         .lane_n    (lanen_v[p]),
         .oe_n      (oen_v[p]),
         .addr      (addr_v[p]),
         .mem_wr    (wr_v[p]),
         .mem_waddr (waddr_v[p]),
         .mem_lanes (lanes_v[p]),
         .mem_raddr (raddr_v[p]),
         .mem_rdata (rdata_v[p]),
         .q         (q_v[p]),
         .q_vld     (qvld_v[p])
      );
   end

   dpr_lvt_bank #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_bank (
      .clk_a   (clk_a),
      .wr_a    (wr_v[0]),
      .waddr_a (waddr_v[0]),
      .lanes_a (lanes_v[0]),
      .wdata_a (a_wdata),
      .raddr_a (raddr_v[0]),
      .rdata_a (rdata_v[0]),
      .clk_b   (clk_b),
      .wr_b    (wr_v[1]),
      .waddr_b (waddr_v[1]),
      .lanes_b (lanes_v[1]),
      .wdata_b (b_wdata),
      .raddr_b (raddr_v[1]),
      .rdata_b (rdata_v[1])
   );

   assign a_q     = q_v[0];
   assign a_q_vld = qvld_v[0];
   assign b_q     = q_v[1];
   assign b_q_vld = qvld_v[1];

endmodule

// File: tb/dpr_sync_ram_test.sv
`timescale 1ns/1ps
module dpr_sync_ram_test;

   typedef struct packed {
      logic        ce0_n;
      logic        ce1;
      logic        rd;
      logic        ld_n;
      logic        adv_n;
      logic        clr_n;
      logic [3:0]  lane_n;
      logic        oe_n;
      logic [7:0]  addr;
      logic [35:0] wdata;
   } cmd_t;

   typedef struct {
      logic        v;
      logic [35:0] d;
      string       tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        a_sel_n, a_sel, a_rd, a_load_n, a_step_n, a_zero_n, a_oe_n;
   logic [3:0]  a_lane_n;
   logic [7:0]  a_addr;
   logic [35:0] a_wdata, a_q;
   logic        a_q_vld;
   logic        b_sel_n, b_sel, b_rd, b_load_n, b_step_n, b_zero_n, b_oe_n;
   logic [3:0]  b_lane_n;
   logic [7:0]  b_addr;
   logic [35:0] b_wdata, b_q;
   logic        b_q_vld;

   dpr_sync_ram uut (
      .clk_a(clk), .rst_a_n(rst_n), .a_sel_n(a_sel_n), .a_sel(a_sel), .a_rd(a_rd),
      .a_load_n(a_load_n), .a_step_n(a_step_n), .a_zero_n(a_zero_n), .a_lane_n(a_lane_n),
      .a_oe_n(a_oe_n), .a_addr(a_addr), .a_wdata(a_wdata), .a_q(a_q), .a_q_vld(a_q_vld),
      .clk_b(clk), .rst_b_n(rst_n), .b_sel_n(b_sel_n), .b_sel(b_sel), .b_rd(b_rd),
      .b_load_n(b_load_n), .b_step_n(b_step_n), .b_zero_n(b_zero_n), .b_lane_n(b_lane_n),
      .b_oe_n(b_oe_n), .b_addr(b_addr), .b_wdata(b_wdata), .b_q(b_q), .b_q_vld(b_q_vld)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   logic [35:0] m_mem [256];
   logic [7:0]  m_cnt  [2];
   logic        m_prev [2];
   logic [35:0] m_last [2];
   logic        cur_oe [2];
   item_t       sq_a [$];
   item_t       sq_b [$];

   task automatic chk(input bit ok, input string tag, input logic [36:0] act, input logic [36:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (valid bit on top)", tag, act, exp);
      end
   endtask

   function automatic cmd_t mk(bit on, bit rd, bit ld, bit adv, bit clr, logic [3:0] lane_n,
                               bit oe_off, logic [7:0] a, logic [35:0] d);
      cmd_t c;
      c.ce0_n = !on;  c.ce1 = 1'b1;  c.rd = rd;
      c.ld_n  = !ld;  c.adv_n = !adv; c.clr_n = !clr;
      c.lane_n = lane_n; c.oe_n = oe_off; c.addr = a; c.wdata = d;
      return c;
   endfunction

   function automatic cmd_t wr(bit ld, bit adv, logic [7:0] a, logic [35:0] d);
      return mk(1, 0, ld, adv, 0, 4'h0, 0, a, d);
   endfunction

   function automatic cmd_t rdc(bit ld, bit adv, logic [7:0] a);
      return mk(1, 1, ld, adv, 0, 4'hF, 0, a, 36'h0);
   endfunction

   function automatic cmd_t off();
      return mk(0, 1, 0, 0, 0, 4'hF, 0, 8'h0, 36'h0);
   endfunction

   task automatic drive(input cmd_t ca, input cmd_t cb);
      a_sel_n = ca.ce0_n; a_sel = ca.ce1; a_rd = ca.rd; a_load_n = ca.ld_n;
      a_step_n = ca.adv_n; a_zero_n = ca.clr_n; a_lane_n = ca.lane_n;
      a_oe_n = ca.oe_n; a_addr = ca.addr; a_wdata = ca.wdata;
      b_sel_n = cb.ce0_n; b_sel = cb.ce1; b_rd = cb.rd; b_load_n = cb.ld_n;
      b_step_n = cb.adv_n; b_zero_n = cb.clr_n; b_lane_n = cb.lane_n;
      b_oe_n = cb.oe_n; b_addr = cb.addr; b_wdata = cb.wdata;
      cur_oe[0] = ca.oe_n;
      cur_oe[1] = cb.oe_n;
   endtask

   task automatic mon_port(input int p);
      item_t       it;
      bit          have;
      logic        ev;
      logic [35:0] eq;
      logic [35:0] aq;
      logic        av;
      have = (p == 0) ? (sq_a.size() >= 3) : (sq_b.size() >= 3);
      if (have) it = (p == 0) ? sq_a.pop_front() : sq_b.pop_front();
      else begin it.v = 0; it.d = '0; it.tag = "R5"; end
      if (it.v) m_last[p] = it.d;
      ev = it.v && !cur_oe[p];
      eq = cur_oe[p] ? 36'h0 : m_last[p];
      aq = (p == 0) ? a_q : b_q;
      av = (p == 0) ? a_q_vld : b_q_vld;
      chk(aq === eq && av === ev, it.tag, {av, aq}, {ev, eq});
   endtask

   task automatic step(input cmd_t ca, input cmd_t cb, input string ta, input string tb);
      cmd_t       c  [2];
      string      t  [2];
      logic [7:0] nx [2];
      logic       s  [2];
      item_t      it;
      @(negedge clk);
      mon_port(0);
      mon_port(1);
      drive(ca, cb);
      c[0] = ca; c[1] = cb; t[0] = ta; t[1] = tb;
      for (int p = 0; p < 2; p++) begin
         s[p] = !c[p].ce0_n && c[p].ce1;
         if (!c[p].clr_n)      nx[p] = 8'h0;
         else if (!c[p].ld_n)  nx[p] = c[p].addr;
         else if (!c[p].adv_n) nx[p] = m_cnt[p] + 8'h1;
         else                  nx[p] = m_cnt[p];
         if (!s[p]) nx[p] = m_cnt[p];
         m_cnt[p] = nx[p];
         if (s[p] && !c[p].rd)
            for (int l = 0; l < 4; l++)
               if (!c[p].lane_n[l]) m_mem[nx[p]][l*9 +: 9] = c[p].wdata[l*9 +: 9];
      end
      for (int p = 0; p < 2; p++) begin
         it.v   = s[p] && m_prev[p] && c[p].rd;
         it.d   = m_mem[nx[p]];
         it.tag = t[p];
         if (p == 0) sq_a.push_back(it); else sq_b.push_back(it);
         m_prev[p] = s[p];
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: run did not finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      cmd_t c;
      for (int i = 0; i < 256; i++) m_mem[i] = '0;
      for (int p = 0; p < 2; p++) begin
         m_cnt[p] = 0; m_prev[p] = 0; m_last[p] = '0;
      end
      drive(off(), off());
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R8: after reset, nothing is valid and the data register is clear
      chk(a_q === 36'h0 && a_q_vld === 1'b0, "R8", {a_q_vld, a_q}, 37'h0);
      chk(b_q === 36'h0 && b_q_vld === 1'b0, "R8", {b_q_vld, b_q}, 37'h0);

      // R1/R2/R3: write burst with load, advance, then hold overwrite
      step(wr(1, 0, 8'd10, 36'h0_1111_1110), off(), "R1", "R7");
      step(wr(0, 1, 8'd0,  36'h0_2222_2221), off(), "R2", "R7");
      step(wr(0, 1, 8'd0,  36'h0_3333_3332), off(), "R2", "R7");
      step(wr(0, 0, 8'd0,  36'h0_4444_4443), off(), "R3", "R7");
      // read burst back
      step(rdc(1, 0, 8'd10), off(), "R1", "R7");
      step(rdc(0, 1, 8'd0),  off(), "R2", "R7");
      step(rdc(0, 1, 8'd0),  off(), "R2", "R7");
      step(rdc(0, 0, 8'd0),  off(), "R3", "R7");
      step(rdc(0, 0, 8'd0),  off(), "R3", "R7");

      // R6: byte-lane masked write
      step(wr(1, 0, 8'd20, 36'hA_AAAA_AAAA), off(), "R6", "R7");
      step(mk(1, 0, 1, 0, 0, 4'b1010, 0, 8'd20, 36'h1_2345_6789), off(), "R6", "R7");
      step(rdc(1, 0, 8'd20), off(), "R6", "R7");
      step(rdc(0, 0, 8'd0),  off(), "R6", "R7");

      // R2: wrap from top to zero
      step(wr(1, 0, 8'd255, 36'h5_5555_5555), off(), "R2", "R7");
      step(wr(0, 1, 8'd0,   36'h6_6666_6666), off(), "R2", "R7");
      step(rdc(1, 0, 8'd255), off(), "R2", "R7");
      step(rdc(0, 1, 8'd0),   off(), "R2", "R7");

      // R4: clear beats load and advance
      step(mk(1, 0, 1, 1, 1, 4'h0, 0, 8'd30, 36'h7_7777_7777), off(), "R4", "R7");
      step(rdc(1, 0, 8'd30), off(), "R4", "R7");
      step(mk(1, 1, 1, 1, 1, 4'hF, 0, 8'd10, 36'h0), off(), "R4", "R7");
      step(rdc(0, 1, 8'd0), off(), "R4", "R7");

      // R7/R8: deselect by high active-low select, then reactivation
      step(wr(1, 0, 8'd40, 36'h8_0808_0808), off(), "R7", "R7");
      c = wr(1, 0, 8'd40, 36'hF_FFFF_FFFF); c.ce0_n = 1'b1;
      step(c, off(), "R7", "R7");
      step(rdc(1, 0, 8'd40), off(), "R8", "R7");
      step(rdc(0, 0, 8'd0),  off(), "R8", "R7");
      // R7: deselect by low active-high select; counter must not move
      step(wr(1, 0, 8'd41, 36'h9_0909_0909), off(), "R7", "R7");
      c = wr(0, 1, 8'd0, 36'hE_EEEE_EEEE); c.ce1 = 1'b0;
      step(c, off(), "R7", "R7");
      step(rdc(0, 0, 8'd0), off(), "R7", "R7");
      step(rdc(0, 0, 8'd0), off(), "R7", "R7");

      // R9: output enable gates data and flag
      step(mk(1, 1, 1, 0, 0, 4'hF, 1, 8'd10, 36'h0), off(), "R9", "R7");
      step(mk(1, 1, 0, 1, 0, 4'hF, 1, 8'd0, 36'h0),  off(), "R9", "R7");
      step(mk(1, 1, 0, 1, 0, 4'hF, 1, 8'd0, 36'h0),  off(), "R9", "R7");
      step(rdc(0, 0, 8'd0), off(), "R9", "R7");
      step(rdc(0, 0, 8'd0), off(), "R9", "R7");
      step(rdc(0, 0, 8'd0), off(), "R9", "R7");
      // R9: mid-cycle toggle without any clock edge
      #3;
      a_oe_n = 1'b1;
      #1;
      chk(a_q === 36'h0 && a_q_vld === 1'b0, "R9", {a_q_vld, a_q}, 37'h0);
      a_oe_n = 1'b0;
      #1;
      chk(a_q === m_mem[8'd12] && a_q_vld === 1'b1, "R9", {a_q_vld, a_q}, {1'b1, m_mem[8'd12]});

      // R10: cross-port visibility
      step(wr(1, 0, 8'd60, 36'hC_0C0C_0C0C), off(), "R10", "R7");
      step(off(), rdc(1, 0, 8'd60), "R7", "R8");
      step(off(), rdc(0, 0, 8'd0),  "R7", "R10");
      step(off(), wr(1, 0, 8'd61, 36'hD_0D0D_0D0D), "R7", "R10");
      step(rdc(1, 0, 8'd61), off(), "R8", "R7");
      step(rdc(0, 0, 8'd0),  off(), "R10", "R7");
      // simultaneous writes to different words, then swapped reads
      step(wr(1, 0, 8'd70, 36'h3_7070_7070), wr(1, 0, 8'd71, 36'h4_7171_7171), "R10", "R10");
      step(rdc(1, 0, 8'd71), rdc(1, 0, 8'd70), "R10", "R10");
      step(rdc(0, 0, 8'd0),  rdc(0, 0, 8'd0),  "R10", "R10");
      // lanes of one word written by both ports on different edges
      step(wr(1, 0, 8'd80, 36'h1_1111_1111), off(), "R10", "R7");
      step(off(), mk(1, 0, 1, 0, 0, 4'b1110, 0, 8'd80, 36'h2_2222_2222), "R7", "R10");
      step(rdc(1, 0, 8'd80), off(), "R10", "R7");
      step(rdc(0, 0, 8'd0),  rdc(1, 0, 8'd80), "R10", "R10");
      step(rdc(0, 0, 8'd0),  rdc(0, 0, 8'd0),  "R10", "R10");

      // drain the pipeline
      for (int i = 0; i < 4; i++) step(off(), off(), "R5", "R5");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule